// File: doc/BRIEF.md
# XOR-Encoded Register Update Sequencer

This block is a host-side controller for a configuration register that cannot be set with a plain write. The register keeps its contents in an encoded form. To make the register hold a chosen value, the host must first read a companion status register and then the target register. It combines the two readings with XOR, applies XOR again with the value it wants, and writes that result back to the target. The sequencer performs these steps by itself after a single start command.

The sequencer uses a generic single-beat register bus. A transfer is offered with a request strobe, an address, a write flag and write data. It completes in the cycle where the device raises ready while the request is high. Read data is taken in that same cycle. When the sequence ends, a one-cycle done pulse is raised and the controller returns to idle.

On the target device, two bits of the resulting configuration matter to its clocking. Bit 6 selects the delay-locked loop range: 1 selects the fast range (the default, 80 MSPS up to the maximum rate) and 0 selects the slow range (40 to 100 MSPS). Bit 4 turns on double-data-rate output.

Top module: `xor_reg_sequencer`

## Requirements
- R1: After reset the sequencer is idle, with busy_o, done_o and bus_req_o all low.
- R2: A start_i sampled while idle makes the next cycle a read request (bus_we_o = 0) to the status address, 0x75 by default.
- R3: The read of the status address is followed by a read of the target address, 0x74 by default, and then by a write (bus_we_o = 1) to the target address. No other bus transfers occur in a sequence.
- R4: The write data equals desired XOR status-read XOR target-read, where desired is the value latched from desired_i when the sequence was started.
- R5: While bus_req_o is high and bus_ready_i is low, bus_req_o, bus_addr_o, bus_we_o and bus_wdata_o hold their values into the next cycle.
- R6: The cycle after the write is accepted, done_o is high for exactly one cycle. In the cycle after that, busy_o is low.
- R7: A start_i that arrives while busy_o is high is ignored. It neither restarts the sequence nor replaces the latched desired value.
- R8: For a device that sets its effective configuration to written XOR status XOR previously stored value, the effective configuration equals the desired value after each completed sequence. This includes bit 6 (DLL range, 1 = fast) and bit 4 (double-data-rate enable).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begin an update sequence (honoured only when idle) |
| desired_i | input | DATA_W | Configuration value the target should end up with |
| busy_o | output | 1 | High from the cycle after an accepted start until the return to idle |
| done_o | output | 1 | One-cycle pulse at the end of a sequence |
| bus_req_o | output | 1 | Bus transfer request |
| bus_we_o | output | 1 | 1 = write, 0 = read |
| bus_addr_o | output | ADDR_W | Register address |
| bus_wdata_o | output | DATA_W | Write data |
| bus_rdata_i | input | DATA_W | Read data, valid when bus_ready_i is high |
| bus_ready_i | input | 1 | Transfer completes in a cycle where this and bus_req_o are high |

## Verification
The assertions check the bus rules on every cycle. They cover requests held stable under backpressure, the status read that follows an accepted start, the status-then-target ordering, and the single-cycle done pulse that follows an accepted write. The XOR arithmetic of the written value cannot be seen at the ports in one cycle, so only the bench's scenarios show it. The same holds for the device's effective value matching the desired one, and for a mid-sequence start leaving the latched value untouched. To cover these, the bench sweeps all desired codes against several status and stored patterns, with varying ready delays.

// File: rtl/xor_reg_sequencer.sv
module xor_reg_sequencer #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] TARGET_ADDR = 8'h74,
  parameter logic [ADDR_W-1:0] STATUS_ADDR = 8'h75
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [DATA_W-1:0] desired_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              bus_req_o,
  output logic              bus_we_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic [DATA_W-1:0] bus_wdata_o,
  input  logic [DATA_W-1:0] bus_rdata_i,
  input  logic              bus_ready_i
);

  typedef enum logic [2:0] {IDLE, RD_STATUS, RD_TARGET, WRITE, DONE} state_t;

  state_t            state;
  logic [DATA_W-1:0] want;
  logic [DATA_W-1:0] acc;
  logic              xfer;

  assign xfer        = bus_req_o && bus_ready_i;
  assign busy_o      = (state != IDLE);
  assign done_o      = (state == DONE);
  assign bus_req_o   = (state == RD_STATUS) || (state == RD_TARGET) || (state == WRITE);
  assign bus_we_o    = (state == WRITE);
  assign bus_addr_o  = (state == RD_STATUS) ? STATUS_ADDR : TARGET_ADDR;
  assign bus_wdata_o = (state == WRITE) ? (acc ^ want) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= IDLE;
      want  <= '0;
      acc   <= '0;
    end else begin
      case (state)
        IDLE: if (start_i) begin
          want  <= desired_i;
          state <= RD_STATUS;
        end
        RD_STATUS: if (xfer) begin
          acc   <= bus_rdata_i;
          state <= RD_TARGET;
        end
        RD_TARGET: if (xfer) begin
          acc   <= acc ^ bus_rdata_i;
          state <= WRITE;
        end
        WRITE: if (xfer) state <= DONE;
        DONE: state <= IDLE;
        default: state <= IDLE;
      endcase
    end
  end

endmodule

// File: rtl/xor_reg_sequencer_chk.sv
module xor_reg_sequencer_chk #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] TARGET_ADDR = 8'h74,
  parameter logic [ADDR_W-1:0] STATUS_ADDR = 8'h75
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_i,
  input logic              busy_o,
  input logic              done_o,
  input logic              bus_req_o,
  input logic              bus_we_o,
  input logic [ADDR_W-1:0] bus_addr_o,
  input logic [DATA_W-1:0] bus_wdata_o,
  input logic              bus_ready_i
);

  assert_start_reads_status_R2: assert property (@(posedge clk) disable iff (!rst_n)
    start_i && !busy_o |=> bus_req_o && !bus_we_o && bus_addr_o == STATUS_ADDR);

  assert_target_after_status_R3: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req_o && bus_ready_i && !bus_we_o && bus_addr_o == STATUS_ADDR
    |=> bus_req_o && !bus_we_o && bus_addr_o == TARGET_ADDR);

  assert_write_to_target_R3: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req_o && bus_we_o |-> bus_addr_o == TARGET_ADDR);

  assert_hold_under_wait_R5: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req_o && !bus_ready_i |=> bus_req_o && $stable(bus_addr_o) && $stable(bus_we_o)
    && $stable(bus_wdata_o));

  assert_done_after_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req_o && bus_we_o && bus_ready_i |=> done_o);

  assert_done_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o && !busy_o);

  assert_done_quiet_bus_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !bus_req_o);

endmodule

bind xor_reg_sequencer xor_reg_sequencer_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .TARGET_ADDR(TARGET_ADDR), .STATUS_ADDR(STATUS_ADDR)
) u_chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .busy_o(busy_o), .done_o(done_o),
  .bus_req_o(bus_req_o), .bus_we_o(bus_we_o), .bus_addr_o(bus_addr_o),
  .bus_wdata_o(bus_wdata_o), .bus_ready_i(bus_ready_i)
);

// File: tb/test_xor_reg_sequencer.sv
module test_xor_reg_sequencer;
  logic       clk = 0;
  logic       rst_n = 0;
  logic       start = 0;
  logic [7:0] desired = 0;
  logic       busy, done, req, we, ready;
  logic [7:0] addr, wdata, rdata;

  always #2 clk = ~clk;

  xor_reg_sequencer i_xor_reg_sequencer (
    .clk(clk), .rst_n(rst_n), .start_i(start), .desired_i(desired),
    .busy_o(busy), .done_o(done), .bus_req_o(req), .bus_we_o(we),
    .bus_addr_o(addr), .bus_wdata_o(wdata), .bus_rdata_i(rdata), .bus_ready_i(ready)
  );

  // device model
  logic [7:0] stat = 8'h00;
  logic [7:0] stored = 8'h10;
  logic [7:0] eff = 8'h00;
  logic [1:0] dly = 0;
  logic [2:0] wcnt = 0;

  assign ready = req && (wcnt >= {1'b0, dly});
  assign rdata = (addr == 8'h75) ? stat : stored;

  always_ff @(posedge clk) begin
    if (req && !ready) wcnt <= wcnt + 3'd1;
    else wcnt <= 3'd0;
    if (req && ready && we) begin
      eff    <= wdata ^ stat ^ stored;
      stored <= wdata;
    end
  end

  int checks = 0;
  int errors = 0;
  logic [7:0] log_addr [4];
  logic       log_we [4];
  logic [7:0] log_wdata;
  int         log_n = 0;

  always @(negedge clk) begin
    if (req && ready) begin
      if (log_n < 4) begin
        log_addr[log_n] = addr;
        log_we[log_n]   = we;
      end
      if (we) log_wdata = wdata;
      log_n = log_n + 1;
    end
  end

  task automatic check(input bit ok, input string req_tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req_tag, act, exp);
    end
  endtask

  task automatic run_seq(input logic [7:0] d, input bit inject);
    logic [7:0] st0, sv0, exp_w;
    int k;
    st0 = stat; sv0 = stored;
    exp_w = d ^ st0 ^ sv0;
    @(negedge clk);
    start = 1; desired = d; log_n = 0;
    @(negedge clk);
    start = 0;
    if (inject) desired = ~d;
    check(req && !we && addr == 8'h75, "R2 status read", {req, we, addr}, {2'b10, 8'h75});
    k = 0;
    while (!done && k < 64) begin
      @(negedge clk);
      k++;
      start = inject && (k == 1);
    end
    start = 0;
    check(done, "R6 done seen", done, 1);
    check(log_n == 3, "R3 transfer count", log_n, 3);
    check(log_addr[0] == 8'h75 && !log_we[0], "R3 first read", log_addr[0], 8'h75);
    check(log_addr[1] == 8'h74 && !log_we[1], "R3 second read", log_addr[1], 8'h74);
    check(log_addr[2] == 8'h74 && log_we[2], "R3 write", log_addr[2], 8'h74);
    if (inject) check(log_wdata == exp_w, "R7 ignored start", log_wdata, exp_w);
    else        check(log_wdata == exp_w, "R4 write data", log_wdata, exp_w);
    check(eff == d, "R8 effective value", eff, d);
    @(negedge clk);
    check(!done && !busy, "R6 single pulse idle", {done, busy}, 0);
    check(log_n == 3, "R7 no restart", log_n, 3);
  endtask

  initial begin
    logic [7:0] pats [4];
    logic [7:0] lfsr;
    pats[0] = 8'h00; pats[1] = 8'hFF; pats[2] = 8'h5A; pats[3] = 8'hC3;
    lfsr = 8'h1;
    repeat (3) @(negedge clk);
    check(!busy && !done && !req, "R1 reset state", {busy, done, req}, 0);
    rst_n = 1;
    @(negedge clk);
    check(!busy && !done && !req, "R1 after reset", {busy, done, req}, 0);
    for (int p = 0; p < 4; p++) begin
      stat = pats[p];
      for (int d = 0; d < 256; d++) begin
        dly  = lfsr[1:0];
        lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        run_seq(d[7:0], (d % 7) == 3);
      end
    end
    // R8 named configuration bits: fast DLL with DDR, slow DLL without DDR
    run_seq(8'h50, 0);
    check(eff[6] && eff[4], "R8 fast dll ddr on", eff, 8'h50);
    run_seq(8'h00, 0);
    check(!eff[6] && !eff[4], "R8 slow dll ddr off", eff, 8'h00);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule